// File: doc/BRIEF.md
# Stretchable External Data Memory Cycle Generator

This block carries out one external data memory transfer, read or write, for an 8051-style core. An accepted request goes through three stages. The low address byte is first placed on a shared address/data bus while an address latch enable pulses. Next comes an active-low read or write strobe. The access then ends with a one-clock done pulse. The high address byte sits on its own port for the whole transfer.

The length of the transfer is set by a 3-bit stretch field, and so is the width of its strobe. Software writes this field through a special-function-register write port. One machine cycle is four clocks, and an access lasts 2 + stretch machine cycles. The strobe lasts 2 clocks at stretch 0 and 4 × stretch clocks otherwise. After reset the field holds 1, so the block does not start at full speed. Slow RAMs and memory-mapped peripherals can be served without glue logic by raising the stretch. Program memory fetches never pass through this block.

Top module: `xmem_cycle_gen`

## Requirements
- R1: After reset the stretch field is 1, so the first access takes 12 clocks and its strobe is low for 4 clocks.
- R2: An accepted access lasts exactly 4 × (2 + s) clocks, counted from the clock after the accepting edge, where s is the stretch value. done_o is high only in the last of those clocks.
- R3: The strobe is low for 2 clocks when s = 0 and for 4 × s clocks when s is 1 to 7.
- R4: ale_o is high in the first 2 clocks of an access, with bus_oe_o high and bus_o equal to address bits 7..0. The strobe falls in clock 3, one clock after ale_o falls.
- R5: hi_addr_o equals address bits 15..8 in every clock of an access.
- R6: In a write (req_wr_i = 1), bus_o carries the write data with bus_oe_o high from clock 2 to the end of the access. wr_no returns high at least one clock before the access ends.
- R7: In a read (req_wr_i = 0), bus_oe_o is low from clock 2 to the end. rdata_o takes the value of bus_i at the clock edge that ends the last strobe-low clock.
- R8: A read lowers only rd_no and a write lowers only wr_no. The two are never low together.
- R9: A register write changes the stretch only when sfr_addr_i is 0x8E, and only bits 2..0 of the data are used. Writes to any other address leave the stretch unchanged.
- R10: A stretch write made during an access does not change that access. It applies from the next access on.
- R11: start_i is ignored while an access is in progress. No extra access follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register write address |
| sfr_wdata_i | input | 8 | Register write data |
| start_i | input | 1 | Access request, taken only when idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Write data |
| bus_i | input | 8 | Shared bus value seen from the pins |
| bus_o | output | 8 | Shared bus drive value |
| bus_oe_o | output | 1 | Shared bus output enable |
| hi_addr_o | output | 8 | High address byte |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| rdata_o | output | 8 | Captured read data |
| done_o | output | 1 | One-clock end-of-access pulse |

## Verification
Clock numbering starts at 0 with the clock after the edge that accepts start_i. Address latch enable is then due in clocks 0 and 1, and the strobe from clock 3 through clock 2 + width. done_o is due in clock 4 × (2 + s) − 1, and rdata_o is valid from the edge that ends the last strobe clock. The bench samples every output at the falling edge and indexes each sample by that clock number, so every expectation is compared in the clock where the result is due. It changes bus_i at every falling edge, which means a read check passes only if the capture happens at the right edge. Stretch values are swept over all eight settings for both reads and writes.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // total clocks of one access
  function automatic int unsigned access_clks(int unsigned s, int unsigned mc);
    return mc * (2 + s);
  endfunction

  // strobe low time in clocks
  function automatic int unsigned strobe_clks(int unsigned s, int unsigned mc);
    return (s == 0) ? mc / 2 : mc * s;
  endfunction
endpackage

// File: rtl/xmem_stretch_reg.sv
module xmem_stretch_reg #(
  parameter int         STR_W    = 3,
  parameter logic [7:0] SFR_ADDR = 8'h8E,
  parameter int         STR_RST  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [STR_W-1:0] stretch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          stretch_o <= STR_W'(STR_RST);
    else if (we_i && addr_i == SFR_ADDR)  stretch_o <= wdata_i[STR_W-1:0];
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int CLK_PER_MC = 4,
  parameter int STR_W      = 3,
  parameter int CNT_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [STR_W-1:0] stretch_i,
  output logic             accept_o,
  output phase_e           phase_o,
  output logic             cap_o,
  output logic             last_o
);
  localparam int ALE_LEN   = CLK_PER_MC / 2;
  localparam int STB_START = ALE_LEN + 1;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q, tot_last_q, stb_last_q;

  assign accept_o = start_i && !active_q;
  assign last_o   = active_q && (cnt_q == tot_last_q);
  assign cap_o    = active_q && (cnt_q == stb_last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      tot_last_q <= '0;
      stb_last_q <= '0;
    end else if (accept_o) begin
      active_q   <= 1'b1;
      cnt_q      <= '0;
      // stretch latched here: later writes wait for the next access
      tot_last_q <= CNT_W'(access_clks(int'(stretch_i), CLK_PER_MC) - 1);
      stb_last_q <= CNT_W'(STB_START + strobe_clks(int'(stretch_i), CLK_PER_MC) - 1);
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        cnt_q    <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!active_q)                          phase_o = PH_IDLE;
    else if (cnt_q < CNT_W'(ALE_LEN))       phase_o = PH_ALE;
    else if (cnt_q < CNT_W'(STB_START))     phase_o = PH_SETUP;
    else if (cnt_q <= stb_last_q)           phase_o = PH_STROBE;
    else                                    phase_o = PH_HOLD;
  end
endmodule

// File: rtl/xmem_bus_drv.sv
module xmem_bus_drv
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int HI_W   = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  phase_e            phase_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic [HI_W-1:0]   hi_addr_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] rdata_o
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        wr_q    <= wr_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (cap_i && !wr_q) rdata_o <= bus_i;
    end
  end

  logic busy;
  assign busy      = (phase_i != PH_IDLE);
  assign ale_o     = (phase_i == PH_ALE);
  assign rd_no     = !((phase_i == PH_STROBE) && !wr_q);
  assign wr_no     = !((phase_i == PH_STROBE) && wr_q);
  assign hi_addr_o = addr_q[ADDR_W-1:DATA_W];
  assign bus_oe_o  = ale_o || (busy && wr_q);
  assign bus_o     = ale_o ? addr_q[DATA_W-1:0] : (busy && wr_q) ? wdata_q : '0;
endmodule

// File: rtl/xmem_cycle_gen.sv
module xmem_cycle_gen
  import xmem_pkg::*;
#(
  parameter int         CLK_PER_MC = 4,
  parameter int         ADDR_W     = 16,
  parameter int         DATA_W     = 8,
  parameter int         STR_W      = 3,
  parameter logic [7:0] SFR_ADDR   = 8'h8E,
  parameter int         STR_RST    = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sfr_we_i,
  input  logic [7:0]               sfr_addr_i,
  input  logic [7:0]               sfr_wdata_i,
  input  logic                     start_i,
  input  logic                     req_wr_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic [DATA_W-1:0]        bus_i,
  output logic [DATA_W-1:0]        bus_o,
  output logic                     bus_oe_o,
  output logic [ADDR_W-DATA_W-1:0] hi_addr_o,
  output logic                     ale_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o
);
  localparam int MAX_CLKS = CLK_PER_MC * (2 + (1 << STR_W) - 1);
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  logic [STR_W-1:0] stretch;
  logic             accept, cap;
  phase_e           phase;

  xmem_stretch_reg #(
    .STR_W(STR_W), .SFR_ADDR(SFR_ADDR), .STR_RST(STR_RST)
  ) u_str (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(sfr_we_i),
    .addr_i(sfr_addr_i), .wdata_i(sfr_wdata_i), .stretch_o(stretch)
  );

  xmem_seq #(
    .CLK_PER_MC(CLK_PER_MC), .STR_W(STR_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stretch_i(stretch),
    .accept_o(accept), .phase_o(phase), .cap_o(cap), .last_o(done_o)
  );

  xmem_bus_drv #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .wr_i(req_wr_i),
    .addr_i(req_addr_i), .wdata_i(req_wdata_i), .phase_i(phase), .cap_i(cap),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o), .hi_addr_o(hi_addr_o),
    .ale_o(ale_o), .rd_no(rd_no), .wr_no(wr_no), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/xmem_cycle_gen_chk.sv
module xmem_cycle_gen_chk #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] bus_o,
  input logic              bus_oe_o,
  input logic [HI_W-1:0]   hi_addr_o,
  input logic              ale_o,
  input logic              rd_no,
  input logic              wr_no,
  input logic              done_o
);
  p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  p_ale_no_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no));

  p_strobe_after_ale_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_no) || $fell(wr_no)) |-> (!ale_o && $past(!ale_o)));

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hi_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |=> (!(!rd_no || !wr_no) || $stable(hi_addr_o)));

  p_wr_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> bus_oe_o);

  p_wr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> (bus_oe_o && $stable(bus_o)));

  p_rd_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !bus_oe_o);

  p_done_no_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_no && wr_no && !ale_o));
endmodule

bind xmem_cycle_gen xmem_cycle_gen_chk #(.DATA_W(DATA_W), .HI_W(ADDR_W - DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
  .hi_addr_o(hi_addr_o), .ale_o(ale_o), .rd_no(rd_no), .wr_no(wr_no),
  .done_o(done_o)
);

// File: tb/xmem_cycle_gen_tb.sv
module xmem_cycle_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = '0, sfr_wdata = '0;
  logic        start = 1'b0, req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_in = '0;
  logic [7:0]  bus_out, rdata, hi_addr;
  logic        bus_oe, ale, rd_n, wr_n, done;

  int tests = 0, fails = 0;
  bit finished = 0;
  int cur_s = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_cycle_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sfr_we_i(sfr_we), .sfr_addr_i(sfr_addr),
    .sfr_wdata_i(sfr_wdata), .start_i(start), .req_wr_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .bus_i(bus_in),
    .bus_o(bus_out), .bus_oe_o(bus_oe), .hi_addr_o(hi_addr), .ale_o(ale),
    .rd_no(rd_n), .wr_no(wr_n), .rdata_o(rdata), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  // runs one access; s = stretch expected for it
  task automatic access(input logic w, input logic [15:0] a, input logic [7:0] d,
                        input int s, input bit mid_sfr, input logic [7:0] new_s,
                        input bit mid_start, input string tag);
    int exp_tot, exp_w, n_tot, stb_first, stb_last, stb_n, ale_bad, hi_bad;
    int wrong_stb, data_bad, done_n;
    logic [7:0] exp_rd;
    exp_tot = 4 * (2 + s);
    exp_w   = (s == 0) ? 2 : 4 * s;
    stb_first = -1; stb_last = -1; stb_n = 0; ale_bad = 0; hi_bad = 0;
    wrong_stb = 0; data_bad = 0; done_n = 0; n_tot = 0; exp_rd = '0;
    @(negedge clk);
    start = 1'b1; req_wr = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    start = 1'b0; req_addr = ~a; req_wdata = ~d; req_wr = ~w;
    for (int n = 0; n < 64; n++) begin
      if (ale != (n < 2)) ale_bad++;
      if (n < 2 && !(bus_oe && bus_out == a[7:0])) ale_bad++;
      if (hi_addr != a[15:8]) hi_bad++;
      if ((w && !rd_n) || (!w && !wr_n)) wrong_stb++;
      if (n >= 2) begin
        if (w && !(bus_oe && bus_out == d)) data_bad++;
        if (!w && bus_oe) data_bad++;
      end
      if (done) done_n++;
      bus_in = 8'(n * 37 + 11 + a[3:0]);
      if (!rd_n || !wr_n) begin
        if (stb_first < 0) stb_first = n;
        stb_last = n;
        stb_n++;
        if (!rd_n) exp_rd = bus_in;
      end
      if (mid_sfr && n == 4) begin sfr_we = 1'b1; sfr_addr = 8'h8E; sfr_wdata = new_s; end
      if (mid_sfr && n == 5) sfr_we = 1'b0;
      if (mid_start && n == 5) begin start = 1'b1; req_wr = w; req_addr = a; end
      if (mid_start && n == 6) start = 1'b0;
      if (done) begin n_tot = n + 1; break; end
      @(negedge clk);
    end
    check(n_tot == exp_tot, {tag, " R2 access length"}, n_tot, exp_tot);
    check(done_n == 1, {tag, " R2 done pulses"}, done_n, 1);
    check(stb_n == exp_w && stb_last - stb_first + 1 == exp_w, {tag, " R3 strobe width"}, stb_n, exp_w);
    check(stb_first == 3, {tag, " R4 strobe start"}, stb_first, 3);
    check(ale_bad == 0, {tag, " R4 ale/low address"}, ale_bad, 0);
    check(hi_bad == 0, {tag, " R5 high address"}, hi_bad, 0);
    check(wrong_stb == 0, {tag, " R8 strobe select"}, wrong_stb, 0);
    if (w) begin
      check(data_bad == 0, {tag, " R6 write data drive"}, data_bad, 0);
      check(stb_last < n_tot - 1, {tag, " R6 write hold"}, stb_last, n_tot - 2);
    end else begin
      check(data_bad == 0, {tag, " R7 bus released"}, data_bad, 0);
      check(rdata == exp_rd, {tag, " R7 read data"}, rdata, exp_rd);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ale == 0 && rd_n && wr_n && !done && !bus_oe, "reset outputs", {ale, rd_n, wr_n, done, bus_oe}, 5'b01100);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default stretch of one
    access(1'b0, 16'h12A5, 8'h00, 1, 0, 8'h0, 0, "R1 default");
    access(1'b1, 16'hC33C, 8'h5A, 1, 0, 8'h0, 0, "R1 default wr");
    // sweep all stretch values, both directions (R2 R3)
    for (int s = 0; s < 8; s++) begin
      sfr_write(8'h8E, 8'(s | 8'hF8));
      access(1'b0, 16'(16'h0100 * s + 16'h0033 + s), 8'h00, s, 0, 8'h0, 0, "sweep rd");
      access(1'b1, 16'(16'hF000 - 16'h0101 * s), 8'(8'hA0 + s), s, 0, 8'h0, 0, "sweep wr");
    end
    // R9: other addresses ignored
    sfr_write(8'h8E, 8'h02);
    sfr_write(8'h8F, 8'h07);
    sfr_write(8'h0E, 8'h00);
    access(1'b0, 16'h4455, 8'h00, 2, 0, 8'h0, 0, "R9 wrong addr");
    // R10: mid-access write applies later
    access(1'b1, 16'h7788, 8'h3C, 2, 1, 8'h05, 0, "R10 current");
    access(1'b0, 16'h99AA, 8'h00, 5, 0, 8'h0, 0, "R10 next");
    // R11: start during access ignored
    access(1'b0, 16'hBEEF, 8'h00, 5, 0, 8'h0, 1, "R11 busy start");
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (ale || !rd_n || !wr_n || done) extra++;
      end
      check(extra == 0, "R11 no extra access", extra, 0);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule